// File: doc/BRIEF.md
# Overcurrent Fault Counter with Hiccup Restart Sequencer

This block sits next to the switching controller of a synchronous buck converter. Once per switching cycle it receives the overcurrent comparator results for the high-side and the low-side switch. It keeps an up/down count of those results. When the count climbs to the fault level, the block declares a fault and stops switching. It then steps the soft-start timer through a run of throw-away timeouts before it allows one real restart.

The number of throw-away timeouts depends on when the fault happened. A fault that arises while the converter is still starting up gets one more timeout than a fault that arises in normal running. The restart loop has no retry limit, so a lasting short keeps the converter cycling. Sensing, the trip threshold and the soft-start ramp itself are outside this block. The block only sees a one-cycle pulse each time the ramp times out, and it drives a low-for-one-cycle reset onto that ramp.

Top module: `ocp_hiccup`

## Requirements
- R1: A synchronous reset, `rst` high at a clock edge, puts the block in normal running with a fault count of zero. In that state `faultFlag`=0, `swDisable`=0 and `ssEnable`=1.
- R2: In normal running, a clock edge with `cycleStrobe`=1 and either `ocHigh` or `ocLow` (or both) at 1 raises the count by one.
- R3: In normal running, a clock edge with `cycleStrobe`=1 and both OC flags at 0 lowers the count by one. At zero the count stays at zero.
- R4: The edge on which the count reaches 3 declares the fault. From the next cycle on, `faultFlag`=1 and `swDisable`=1.
- R5: A fault declared while `startupPhase`=0 gives 4 dummy soft-start timeouts, then one real restart. `ssEnable` goes low for 5 single cycles in total before `faultFlag` clears.
- R6: The value of `startupPhase` on the declaring edge is latched. If it is 1, the block gives 5 dummy timeouts and `ssEnable` goes low 6 times. Changes of `startupPhase` after that edge have no effect on this sequence.
- R7: `ssEnable` goes low for exactly one cycle in three places: on fault entry, after each `ssDone` pulse seen while waiting for a timeout, and at the real restart.
- R8: The real restart returns the block to normal running with `faultFlag`=0 and `swDisable`=0 and a count of zero. A new fault then needs three more net OC cycles, and the sequence repeats without limit.
- R9: During the restart sequence, OC flags and strobes are ignored. In normal running, `ssDone` is ignored.
- R10: With `cycleStrobe`=0 the count does not change, whatever the OC flags are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cycleStrobe | input | 1 | One pulse per switching cycle; qualifies the OC flags |
| ocHigh | input | 1 | High-side switch overcurrent comparator result |
| ocLow | input | 1 | Low-side switch overcurrent comparator result |
| ssDone | input | 1 | One-cycle pulse when the soft-start ramp times out |
| startupPhase | input | 1 | High while the converter is still in its initial start-up |
| faultFlag | output | 1 | High from fault declaration until the real restart |
| ssEnable | output | 1 | Low for one cycle to reset and restart the soft-start ramp |
| swDisable | output | 1 | High while switching must be held off |

## Verification
A wrong fault count stays hidden until it matters. It shows up as a fault declared one strobe too early or too late. That can take several switching cycles after the bad count arose, so the bench compares all three outputs on every cycle against an independent model. A wrong dummy count shows up only at the end of a restart sequence. It is seen as one `ssEnable` pulse too many or too few before `faultFlag` falls, so the bench counts those pulses over whole sequences started in both phases.

// File: rtl/ocp_pkg.sv
`timescale 1ns/1ps
package ocp_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_GAP  = 2'd1,
    ST_WAIT = 2'd2
  } hicState_t;

  typedef struct packed {
    logic cntEn;
    logic cntClear;
    logic dumLoad;
    logic dumDec;
  } ctrlStrobes_t;

endpackage

// File: rtl/ocp_datapath.sv
`timescale 1ns/1ps
module ocp_datapath
  import ocp_pkg::*;
#(
  parameter int FAULT_LEVEL   = 3,
  parameter int DUMMY_NORMAL  = 4,
  parameter int DUMMY_STARTUP = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cycleStrobe,
  input  logic         ocHigh,
  input  logic         ocLow,
  input  logic         startupPhase,
  input  ctrlStrobes_t ctrl,
  output logic         tripNow,
  output logic         dumZero
);

  localparam int DUM_MAX = (DUMMY_STARTUP > DUMMY_NORMAL) ? DUMMY_STARTUP : DUMMY_NORMAL;
  localparam int CW = $clog2(FAULT_LEVEL + 1);
  localparam int DW = $clog2(DUM_MAX + 1);
  localparam logic [CW-1:0] CNT_TOP  = CW'(FAULT_LEVEL);
  localparam logic [CW-1:0] CNT_PRE  = CW'(FAULT_LEVEL - 1);
  localparam logic [DW-1:0] LOAD_NRM = DW'(DUMMY_NORMAL);
  localparam logic [DW-1:0] LOAD_STU = DW'(DUMMY_STARTUP);

  logic          ocAny;
  logic [CW-1:0] cnt;
  logic [DW-1:0] dumLeft;

  assign ocAny = ocHigh | ocLow;

  // up/down fault count, floor at zero, ceiling at the fault level
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (ctrl.cntClear) begin
      cnt <= '0;
    end else if (ctrl.cntEn && cycleStrobe) begin
      if (ocAny) begin
        if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
      end else begin
        if (cnt != '0) cnt <= cnt - 1'b1;
      end
    end
  end

  assign tripNow = ctrl.cntEn & cycleStrobe & ocAny & (cnt == CNT_PRE);

  // remaining dummy timeouts; the phase flag is captured by the load
  always_ff @(posedge clk) begin
    if (rst) begin
      dumLeft <= '0;
    end else if (ctrl.dumLoad) begin
      dumLeft <= startupPhase ? LOAD_STU : LOAD_NRM;
    end else if (ctrl.dumDec && dumLeft != '0) begin
      dumLeft <= dumLeft - 1'b1;
    end
  end

  assign dumZero = (dumLeft == '0);

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_TOP);

  a_r2_count_up: assert property (@(posedge clk) disable iff (rst)
    (ctrl.cntEn && !ctrl.cntClear && cycleStrobe && ocAny && cnt < CNT_TOP)
      |=> (cnt == $past(cnt) + 1'b1));

  a_r3_floor_zero: assert property (@(posedge clk) disable iff (rst)
    (ctrl.cntEn && !ctrl.cntClear && cycleStrobe && !ocAny && cnt == '0) |=> (cnt == '0));

  a_r10_no_strobe_hold: assert property (@(posedge clk) disable iff (rst)
    (!cycleStrobe && !ctrl.cntClear) |=> $stable(cnt));

  a_r6_startup_load: assert property (@(posedge clk) disable iff (rst)
    (ctrl.dumLoad && startupPhase) |=> (dumLeft == LOAD_STU));

  a_r8_clear_zero: assert property (@(posedge clk) disable iff (rst)
    ctrl.cntClear |=> (cnt == '0));

endmodule

// File: rtl/ocp_control.sv
`timescale 1ns/1ps
module ocp_control
  import ocp_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         ssDone,
  input  logic         tripNow,
  input  logic         dumZero,
  output ctrlStrobes_t ctrl,
  output logic         faultFlag,
  output logic         ssEnable,
  output logic         swDisable
);

  hicState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_RUN:  if (tripNow) stateNxt = ST_GAP;
      ST_GAP:  stateNxt = dumZero ? ST_RUN : ST_WAIT;
      ST_WAIT: if (ssDone) stateNxt = ST_GAP;
      default: stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_RUN;
    else     state <= stateNxt;
  end

  always_comb begin
    ctrl.cntEn    = (state == ST_RUN);
    ctrl.dumLoad  = (state == ST_RUN) && tripNow;
    ctrl.dumDec   = (state == ST_WAIT) && ssDone;
    ctrl.cntClear = (state == ST_GAP) && dumZero;
  end

  assign faultFlag = (state != ST_RUN);
  assign swDisable = (state != ST_RUN);
  assign ssEnable  = (state != ST_GAP);

  a_r7_gap_single: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GAP) |=> (state != ST_GAP));

  a_r4_trip_fault: assert property (@(posedge clk) disable iff (rst)
    tripNow |=> (faultFlag && swDisable && !ssEnable));

  a_r9_wait_hold: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !ssDone) |=> (state == ST_WAIT));

  a_r8_real_start: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GAP && dumZero) |=> (!faultFlag && !swDisable));

  a_r9_run_ignores_done: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && !tripNow) |=> (state == ST_RUN));

endmodule

// File: rtl/ocp_hiccup.sv
`timescale 1ns/1ps
module ocp_hiccup
  import ocp_pkg::*;
#(
  parameter int FAULT_LEVEL   = 3,
  parameter int DUMMY_NORMAL  = 4,
  parameter int DUMMY_STARTUP = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic cycleStrobe,
  input  logic ocHigh,
  input  logic ocLow,
  input  logic ssDone,
  input  logic startupPhase,
  output logic faultFlag,
  output logic ssEnable,
  output logic swDisable
);

  ctrlStrobes_t ctrl;
  logic         tripNow;
  logic         dumZero;

  ocp_datapath #(
    .FAULT_LEVEL  (FAULT_LEVEL),
    .DUMMY_NORMAL (DUMMY_NORMAL),
    .DUMMY_STARTUP(DUMMY_STARTUP)
  ) uDatapath (
    .clk         (clk),
    .rst         (rst),
    .cycleStrobe (cycleStrobe),
    .ocHigh      (ocHigh),
    .ocLow       (ocLow),
    .startupPhase(startupPhase),
    .ctrl        (ctrl),
    .tripNow     (tripNow),
    .dumZero     (dumZero)
  );

  ocp_control uControl (
    .clk      (clk),
    .rst      (rst),
    .ssDone   (ssDone),
    .tripNow  (tripNow),
    .dumZero  (dumZero),
    .ctrl     (ctrl),
    .faultFlag(faultFlag),
    .ssEnable (ssEnable),
    .swDisable(swDisable)
  );

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!faultFlag && ssEnable && !swDisable));

endmodule

// File: tb/tb_ocp_hiccup.sv
`timescale 1ns/1ps
module tb_ocp_hiccup;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cycleStrobe = 1'b0, ocHigh = 1'b0, ocLow = 1'b0, ssDone = 1'b0, startupPhase = 1'b0;
  logic faultFlag, ssEnable, swDisable;

  int testCount = 0;
  int failCount = 0;

  // independent model: 0 run, 1 restart gap, 2 waiting for timeout
  int mState = 0;
  int mCnt   = 0;
  int mLeft  = 0;

  always #2 clk = ~clk;

  ocp_hiccup dut (
    .clk(clk), .rst(rst), .cycleStrobe(cycleStrobe), .ocHigh(ocHigh), .ocLow(ocLow),
    .ssDone(ssDone), .startupPhase(startupPhase),
    .faultFlag(faultFlag), .ssEnable(ssEnable), .swDisable(swDisable)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  function automatic void modelStep(logic s, logic h, logic l, logic d, logic st);
    case (mState)
      0: if (s) begin
           if (h || l) begin
             if (mCnt == 2) begin mCnt = 3; mState = 1; mLeft = st ? 5 : 4; end
             else mCnt++;
           end else if (mCnt > 0) mCnt--;
         end
      1: if (mLeft == 0) begin mState = 0; mCnt = 0; end
         else mState = 2;
      default: if (d) begin mLeft--; mState = 1; end
    endcase
  endfunction

  task automatic step(input logic s, h, l, d, st, input string tag);
    cycleStrobe = s; ocHigh = h; ocLow = l; ssDone = d; startupPhase = st;
    @(posedge clk);
    modelStep(s, h, l, d, st);
    @(negedge clk);
    chk({tag, " faultFlag"}, faultFlag, mState != 0);
    chk({tag, " swDisable"}, swDisable, mState != 0);
    chk({tag, " ssEnable"},  ssEnable,  mState != 1);
  endtask

  // runs a restart sequence to its end; ssDone held high, OC noise applied
  task automatic runHiccup(input int expGaps, input string tag);
    int gaps;
    gaps = (ssEnable == 1'b0) ? 1 : 0;
    for (int i = 0; i < 100 && faultFlag; i++) begin
      step(1'b1, 1'($urandom % 2), 1'($urandom % 2), 1'b1, 1'($urandom % 2), {tag, " R9 noise"});
      if (!ssEnable) gaps++;
    end
    testCount++;
    if (gaps != expGaps) begin
      failCount++;
      $display("FAIL %s: ssEnable low pulses got %0d expected %0d", tag, gaps, expGaps);
    end
  endtask

  initial begin
    #400000;
    failCount++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c0c));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset faultFlag", faultFlag, 1'b0);
    chk("R1 reset ssEnable", ssEnable, 1'b1);
    chk("R1 reset swDisable", swDisable, 1'b0);

    // R2/R4: three OC cycles from either side trip on the third
    step(1, 1, 0, 0, 0, "R2 high side");
    step(1, 0, 1, 0, 0, "R2 low side");
    chk("R4 no fault at two", faultFlag, 1'b0);
    step(1, 1, 1, 0, 0, "R4 trip");
    chk("R4 fault declared", faultFlag, 1'b1);
    chk("R4 switching off", swDisable, 1'b1);
    chk("R7 entry gap", ssEnable, 1'b0);
    // R5/R7: normal-phase fault; startup toggled during must not matter
    runHiccup(5, "R5 normal");
    chk("R8 restart clears fault", faultFlag, 1'b0);

    // R8: count cleared at real start, two OC cycles do not trip
    step(1, 1, 0, 0, 0, "R8 after restart 1");
    step(1, 0, 1, 0, 0, "R8 after restart 2");
    chk("R8 count was cleared", faultFlag, 1'b0);
    // R3: up/down pattern: 2 -> 1 -> 2 -> 3
    step(1, 0, 0, 0, 0, "R3 down");
    step(1, 1, 0, 0, 0, "R3 up again");
    chk("R3 no fault at two", faultFlag, 1'b0);
    // R6: trip in startup phase, latched
    step(1, 1, 0, 0, 1, "R6 trip in startup");
    chk("R6 fault declared", faultFlag, 1'b1);
    runHiccup(6, "R6 startup");

    // R3 floor: many downs then exactly three ups needed
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, "R3 floor");
    step(1, 1, 0, 0, 0, "R3 floor up1");
    step(1, 1, 0, 0, 0, "R3 floor up2");
    chk("R3 floor no fault at two", faultFlag, 1'b0);
    // R10: OC without strobe holds the count; R9: ssDone in run ignored
    for (int i = 0; i < 6; i++) step(0, 1, 1, 1, 0, "R10 no strobe");
    chk("R10 count held", faultFlag, 1'b0);
    chk("R9 ssDone ignored in run", ssEnable, 1'b1);
    step(1, 0, 1, 0, 0, "R10 third up trips");
    chk("R10 trip after hold", faultFlag, 1'b1);
    runHiccup(5, "R5 repeat");

    // constrained random mix checked cycle by cycle against the model
    for (int i = 0; i < 6000; i++) begin
      step(1'(($urandom % 4) != 0), 1'(($urandom % 3) == 0), 1'(($urandom % 4) == 0),
           1'(($urandom % 3) == 0), 1'($urandom % 2), "R2 R3 R5 R6 random");
    end

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule